// File: doc/BRIEF.md
# Phase-Tagged Reply Ring Consumer

This block drains completion entries from a circular reply ring held in local memory. A producer fills the ring with 64-bit entries, and it stamps bit 0 of each entry with a phase value that it inverts every time it wraps. The consumer keeps a head index and the phase value it expects to see. On each poll it reads the entry at the head. If bit 0 of that entry matches the expected phase, the entry is new. The consumer then returns the entry, advances the head and decrements its outstanding-command count. Otherwise it returns an empty sentinel and changes nothing. When the head passes the last slot, it returns to slot 0 and the expected phase inverts. The two sides never exchange pointers.

With message-signalled interrupts off, every poll first acknowledges the doorbell and then reads the doorbell status back, so the acknowledge has landed before the ring is read. A separate query reports whether an interrupt is pending. It reads the interrupt status register and, when needed, the doorbell status. Polls and queries share one register port, so they are handled one at a time, and a poll wins when both arrive together.

The poll, the query and the memory request are valid/ready handshakes. A request is accepted on the cycle in which its valid and ready are both high. A result beat (`res_valid`, `pend_valid`) holds its data steady until the receiver raises the matching ready. While a result is waiting, no new poll or query is accepted, so back-pressure on a result stalls the whole block. Read responses from memory and from registers have no ready signal: the block always accepts them.

Top module: `reply_ring_consumer`

## Requirements
- R1: After reset the head index is 0, the expected phase is 1, the outstanding count is 0 and no result is offered. A poll of a ring cleared to zero therefore returns the sentinel.
- R2: An entry whose bit 0 equals the expected phase is new. The poll returns it unchanged, the head moves to the next slot and the outstanding count falls by one.
- R3: An entry whose bit 0 differs from the expected phase is stale. The poll returns the sentinel 64'h0000_0000_FFFF_FFFF, and both the head and the count keep their values.
- R4: After the entry in slot RING_DEPTH-1 is consumed, the head becomes 0 and the expected phase inverts.
- R5: With `msi_mode` low, each poll writes 32'h1 to register 8'hA0, then reads register 8'h9C, and only then issues the ring read. With `msi_mode` high, a poll makes no register access.
- R6: A pending query reads register 8'h30. A value of zero reports not pending. A nonzero value with `msi_mode` high reports pending. A nonzero value with `msi_mode` low triggers a read of 8'h9C, and bit 0 of that read is the answer.
- R7: Each accepted poll produces exactly one result beat. While `res_valid` is high and `res_ready` is low, `res_data` holds steady and `poll_ready` stays low.
- R8: Each cycle with `cmd_issued` high adds one to the outstanding count, which saturates at all ones. Consuming an entry subtracts one, but never below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | High when interrupts are message-signalled |
| cmd_issued | input | 1 | One pulse per command submitted |
| outstanding | output | CNT_W | Outstanding command count |
| poll_valid | input | 1 | Poll request |
| poll_ready | output | 1 | Poll accepted when both are high |
| res_valid | output | 1 | Poll result offered |
| res_ready | input | 1 | Poll result taken |
| res_data | output | ENTRY_W | Entry or sentinel |
| chk_valid | input | 1 | Pending query request |
| chk_ready | output | 1 | Query accepted |
| pend_valid | output | 1 | Query result offered |
| pend_ready | input | 1 | Query result taken |
| pend_flag | output | 1 | Interrupt pending |
| mem_req_valid | output | 1 | Ring read request |
| mem_req_ready | input | 1 | Ring read accepted |
| mem_req_idx | output | IDX_W | Slot index to read |
| mem_rsp_valid | input | 1 | Ring read data valid |
| mem_rsp_data | input | ENTRY_W | Ring read data |
| reg_valid | output | 1 | Register access request |
| reg_ready | input | 1 | Register access accepted |
| reg_we | output | 1 | High for a write |
| reg_addr | output | 8 | Register offset |
| reg_wdata | output | 32 | Write data |
| reg_rvalid | input | 1 | Register read data valid |
| reg_rdata | input | 32 | Register read data |

## Verification
The assertions assume that memory and register read responses each arrive as a single pulse, only after a read was accepted. They also assume that `msi_mode` changes only while the block is idle. The bench's memory and register models answer exactly one cycle after they accept a read, and they always accept requests. The bench changes `msi_mode` only between operations and writes ring slots only while no poll is in flight.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFS_INT_STAT = 8'h30;
  localparam logic [REG_AW-1:0] OFS_DB_STAT  = 8'h9C;
  localparam logic [REG_AW-1:0] OFS_DB_CLR   = 8'hA0;
  localparam logic [REG_DW-1:0] DB_CLR_VAL   = 32'h0000_0001;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_FLUSH, S_FLUSH_W, S_RING, S_RING_W, S_RES,
    S_STAT, S_STAT_W, S_DBS, S_DBS_W, S_PEND
  } seq_e;
endpackage

// File: rtl/rrc_ring_ptr.sv
module rrc_ring_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] head,
  output logic             phase
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      phase <= 1'b1;
    end else if (step) begin
      if (head == LAST) begin
        head  <= '0;
        phase <= ~phase;
      end else begin
        head <= head + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrc_out_count.sv
module rrc_out_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && !dec) begin
      if (count != TOP) count <= count + 1'b1;
    end else if (dec && !inc) begin
      if (count != '0) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rrc_seq.sv
module rrc_seq
  import rrc_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_mode,
  input  logic [IDX_W-1:0]   head,
  input  logic               phase,
  output logic               consume,
  input  logic               poll_valid,
  output logic               poll_ready,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ENTRY_W-1:0] res_data,
  input  logic               chk_valid,
  output logic               chk_ready,
  output logic               pend_valid,
  input  logic               pend_ready,
  output logic               pend_flag,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [IDX_W-1:0]   mem_req_idx,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               reg_valid,
  input  logic               reg_ready,
  output logic               reg_we,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [REG_DW-1:0]  reg_wdata,
  input  logic               reg_rvalid,
  input  logic [REG_DW-1:0]  reg_rdata
);
  localparam logic [ENTRY_W-1:0] EMPTY_WORD = {{(ENTRY_W-32){1'b0}}, 32'hFFFF_FFFF};

  seq_e               state, nxt;
  logic [ENTRY_W-1:0] res_q;
  logic               pend_q;
  logic               msi_q;
  logic               hit;

  assign hit         = (mem_rsp_data[0] == phase);
  assign consume     = (state == S_RING_W) && mem_rsp_valid && hit;
  assign poll_ready  = (state == S_IDLE);
  assign chk_ready   = (state == S_IDLE) && !poll_valid;
  assign res_valid   = (state == S_RES);
  assign res_data    = res_q;
  assign pend_valid  = (state == S_PEND);
  assign pend_flag   = pend_q;
  assign mem_req_valid = (state == S_RING);
  assign mem_req_idx   = head;
  assign reg_valid   = (state == S_CLR) || (state == S_FLUSH) ||
                       (state == S_STAT) || (state == S_DBS);
  assign reg_we      = (state == S_CLR);
  assign reg_wdata   = (state == S_CLR) ? DB_CLR_VAL : '0;

  always_comb begin
    case (state)
      S_CLR:   reg_addr = OFS_DB_CLR;
      S_STAT:  reg_addr = OFS_INT_STAT;
      default: reg_addr = OFS_DB_STAT;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: begin
        if (poll_valid)     nxt = msi_mode ? S_RING : S_CLR;
        else if (chk_valid) nxt = S_STAT;
      end
      S_CLR:     if (reg_ready) nxt = S_FLUSH;
      S_FLUSH:   if (reg_ready) nxt = S_FLUSH_W;
      S_FLUSH_W: if (reg_rvalid) nxt = S_RING;
      S_RING:    if (mem_req_ready) nxt = S_RING_W;
      S_RING_W:  if (mem_rsp_valid) nxt = S_RES;
      S_RES:     if (res_ready) nxt = S_IDLE;
      S_STAT:    if (reg_ready) nxt = S_STAT_W;
      S_STAT_W: begin
        if (reg_rvalid) begin
          if (reg_rdata == '0 || msi_q) nxt = S_PEND;
          else                          nxt = S_DBS;
        end
      end
      S_DBS:     if (reg_ready) nxt = S_DBS_W;
      S_DBS_W:   if (reg_rvalid) nxt = S_PEND;
      S_PEND:    if (pend_ready) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      res_q  <= '0;
      pend_q <= 1'b0;
      msi_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE) msi_q <= msi_mode;
      if (state == S_RING_W && mem_rsp_valid)
        res_q <= hit ? mem_rsp_data : EMPTY_WORD;
      if (state == S_STAT_W && reg_rvalid)
        pend_q <= (reg_rdata != '0) && msi_q;
      if (state == S_DBS_W && reg_rvalid)
        pend_q <= reg_rdata[0];
    end
  end
endmodule

// File: rtl/reply_ring_consumer.sv
module reply_ring_consumer
  import rrc_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int ENTRY_W    = 64,
  localparam int IDX_W = (RING_DEPTH > 2) ? $clog2(RING_DEPTH) : 1,
  localparam int CNT_W = $clog2(RING_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_mode,
  input  logic               cmd_issued,
  output logic [CNT_W-1:0]   outstanding,
  input  logic               poll_valid,
  output logic               poll_ready,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ENTRY_W-1:0] res_data,
  input  logic               chk_valid,
  output logic               chk_ready,
  output logic               pend_valid,
  input  logic               pend_ready,
  output logic               pend_flag,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [IDX_W-1:0]   mem_req_idx,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               reg_valid,
  input  logic               reg_ready,
  output logic               reg_we,
  output logic [7:0]         reg_addr,
  output logic [31:0]        reg_wdata,
  input  logic               reg_rvalid,
  input  logic [31:0]        reg_rdata
);
  logic [IDX_W-1:0] head_w;
  logic             phase_w;
  logic             consume_w;

  rrc_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(consume_w), .head(head_w), .phase(phase_w)
  );

  rrc_out_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cmd_issued), .dec(consume_w), .count(outstanding)
  );

  rrc_seq #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode),
    .head(head_w), .phase(phase_w), .consume(consume_w),
    .poll_valid(poll_valid), .poll_ready(poll_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .pend_valid(pend_valid), .pend_ready(pend_ready), .pend_flag(pend_flag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_idx(mem_req_idx),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int ENTRY_W = 64,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               poll_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [ENTRY_W-1:0] res_data,
  input logic               pend_valid,
  input logic               cmd_issued,
  input logic [CNT_W-1:0]   outstanding,
  input logic               mem_req_valid,
  input logic               reg_valid,
  input logic [IDX_W-1:0]   head,
  input logic               phase
);
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7
  AST_NO_POLL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !poll_ready); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, pend_valid})); // R7
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_issued |=> (outstanding <= $past(outstanding))); // R8
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (head != $past(head)) |-> ((head == $past(head) + 1'b1) || (head == '0))); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (head == '0)); // R4
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> !mem_req_valid); // R5
endmodule

bind reply_ring_consumer rrc_checker #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_ready(poll_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .pend_valid(pend_valid),
  .cmd_issued(cmd_issued), .outstanding(outstanding), .mem_req_valid(mem_req_valid),
  .reg_valid(reg_valid), .head(head_w), .phase(phase_w)
);

// File: tb/tb_reply_ring_consumer.sv
module tb_reply_ring_consumer;
  localparam int DEPTH = 8;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam logic [63:0] SENT = 64'h0000_0000_FFFF_FFFF;

  logic clk = 0, rst_n = 0, msi_mode = 0, cmd_issued = 0;
  logic [CW-1:0] outstanding;
  logic poll_valid = 0, poll_ready, res_valid, res_ready = 1;
  logic [63:0] res_data;
  logic chk_valid = 0, chk_ready, pend_valid, pend_ready = 1, pend_flag;
  logic mem_req_valid, mem_req_ready = 1;
  logic [IW-1:0] mem_req_idx;
  logic mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic reg_valid, reg_ready = 1, reg_we;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata;
  logic reg_rvalid = 0;
  logic [31:0] reg_rdata = '0;

  always #10 clk = ~clk;

  reply_ring_consumer #(.RING_DEPTH(DEPTH), .ENTRY_W(64)) dut (.*);

  logic [63:0] ring [DEPTH];
  logic [31:0] int_stat = 0, db_stat = 0;
  int ev [16];
  int ev_n = 0;
  int last_idx = -1;
  int beats = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= ring[mem_req_idx];
      last_idx = int'(mem_req_idx);
      if (ev_n < 16) begin ev[ev_n] = 4; ev_n++; end
    end
    reg_rvalid <= reg_valid && reg_ready && !reg_we;
    if (reg_valid && reg_ready) begin
      int code;
      if (reg_we) code = (reg_addr == 8'hA0 && reg_wdata == 32'h1) ? 1 : 9;
      else if (reg_addr == 8'h9C) code = 2;
      else if (reg_addr == 8'h30) code = 3;
      else code = 8;
      reg_rdata <= (reg_addr == 8'h30) ? int_stat : db_stat;
      if (ev_n < 16) begin ev[ev_n] = code; ev_n++; end
    end
    if (res_valid && res_ready) beats++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cmd_issued = 1;
    end
    @(negedge clk) cmd_issued = 0;
  endtask

  task automatic poll(input int hold, output logic [63:0] d);
    ev_n = 0;
    if (hold > 0) res_ready = 0;
    @(negedge clk) poll_valid = 1;
    while (!poll_ready) @(negedge clk);
    @(negedge clk) poll_valid = 0;
    while (!res_valid) @(negedge clk);
    d = res_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 result held", {63'd0, res_valid}, 64'd1);
      chk("R7 data stable", res_data, d);
      chk("R7 no poll while busy", {63'd0, poll_ready}, 64'd0);
    end
    res_ready = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic query(output logic f);
    ev_n = 0;
    @(negedge clk) chk_valid = 1;
    while (!chk_ready) @(negedge clk);
    @(negedge clk) chk_valid = 0;
    while (!pend_valid) @(negedge clk);
    f = pend_flag;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input int i, input logic ph);
    return {32'hC0DE_0000 + 32'(i), 31'(i * 5 + 3), ph};
  endfunction

  task automatic t_reset();
    logic [63:0] d;
    for (int i = 0; i < DEPTH; i++) ring[i] = '0;
    do_reset();
    chk("R1 count zero", 64'(outstanding), 64'd0);
    chk("R1 no result", {63'd0, res_valid}, 64'd0);
    chk("R1 idle ready", {63'd0, poll_ready}, 64'd1);
    poll(0, d);
    chk("R1 zero ring empty", d, SENT);
    chk("R1 head zero", 64'(last_idx), 64'd0);
  endtask

  task automatic t_stale();
    logic [63:0] d;
    issue(2);
    chk("R8 count after issue", 64'(outstanding), 64'd2);
    ring[0] = mk(0, 1'b0);
    poll(0, d);
    chk("R3 stale gives sentinel", d, SENT);
    chk("R3 count kept", 64'(outstanding), 64'd2);
    poll(0, d);
    chk("R3 head kept", 64'(last_idx), 64'd0);
  endtask

  task automatic t_consume();
    logic [63:0] d;
    ring[0] = mk(0, 1'b1);
    ring[1] = mk(1, 1'b1);
    poll(0, d);
    chk("R2 entry0 data", d, mk(0, 1'b1));
    chk("R2 count dec", 64'(outstanding), 64'd1);
    poll(0, d);
    chk("R2 entry1 data", d, mk(1, 1'b1));
    chk("R2 entry1 slot", 64'(last_idx), 64'd1);
    chk("R2 count dec2", 64'(outstanding), 64'd0);
    poll(0, d);
    chk("R2 next slot empty", d, SENT);
    chk("R2 head at 2", 64'(last_idx), 64'd2);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    do_reset();
    issue(DEPTH);
    for (int i = 0; i < DEPTH; i++) ring[i] = mk(i, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      poll(0, d);
      chk("R4 pre-wrap entry", d, mk(i, 1'b1));
    end
    chk("R4 last slot", 64'(last_idx), 64'(DEPTH - 1));
    chk("R4 drained count", 64'(outstanding), 64'd0);
    poll(0, d);
    chk("R4 old phase stale", d, SENT);
    chk("R4 head wrapped", 64'(last_idx), 64'd0);
    ring[0] = mk(40, 1'b0);
    poll(0, d);
    chk("R4 new phase accepted", d, mk(40, 1'b0));
  endtask

  task automatic t_doorbell();
    logic [63:0] d;
    msi_mode = 0;
    poll(0, d);
    chk("R5 access count", 64'(ev_n), 64'd3);
    chk("R5 first clear write", 64'(ev[0]), 64'd1);
    chk("R5 then flush read", 64'(ev[1]), 64'd2);
    chk("R5 then ring read", 64'(ev[2]), 64'd4);
    msi_mode = 1;
    poll(0, d);
    chk("R5 msi no reg", 64'(ev_n), 64'd1);
    chk("R5 msi ring read", 64'(ev[0]), 64'd4);
    msi_mode = 0;
  endtask

  task automatic t_pending();
    logic f;
    int_stat = 0; db_stat = 32'h1;
    query(f);
    chk("R6 zero status", {63'd0, f}, 64'd0);
    chk("R6 zero status one read", 64'(ev_n), 64'd1);
    int_stat = 32'h5; msi_mode = 1;
    query(f);
    chk("R6 msi nonzero", {63'd0, f}, 64'd1);
    msi_mode = 0;
    query(f);
    chk("R6 db bit0 set", {63'd0, f}, 64'd1);
    chk("R6 status then db", 64'(ev[1]), 64'd2);
    db_stat = 32'h2;
    query(f);
    chk("R6 db bit0 clear", {63'd0, f}, 64'd0);
    int_stat = 0;
  endtask

  task automatic t_backpressure();
    logic [63:0] d;
    int b0;
    do_reset();
    ring[0] = mk(7, 1'b1);
    b0 = beats;
    poll(4, d);
    chk("R7 held data", d, mk(7, 1'b1));
    chk("R7 one beat", 64'(beats - b0), 64'd1);
    poll(2, d);
    chk("R7 one beat empty", 64'(beats - b0), 64'd2);
  endtask

  task automatic t_sat();
    logic [63:0] d;
    do_reset();
    issue(20);
    chk("R8 saturate high", 64'(outstanding), 64'd15);
    do_reset();
    ring[0] = mk(9, 1'b1);
    poll(0, d);
    chk("R8 consume at zero", d, mk(9, 1'b1));
    chk("R8 floor zero", 64'(outstanding), 64'd0);
  endtask

  initial begin
    t_reset();
    t_stale();
    t_consume();
    t_wrap();
    t_doorbell();
    t_pending();
    t_backpressure();
    t_sat();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule